// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits beside a flash array on a byte-wide processor bus and watches the write cycles aimed at the array. Flash contents cannot be changed by a plain store. Software must first issue a two-write unlock prefix, then write a command byte. The decoder follows that sequence and issues a one-cycle command strobe carrying the command byte and the array it addresses. Downstream erase and program engines act on that strobe. Only the low part of the address is compared, so the upper address bits may take any value.

Each write counts only while at least one sector-select line is high. Primary select lines address the primary array and boot select lines address the secondary array. The array chosen on the first unlock write must stay the same for the rest of the sequence. A wrong byte, a wrong address, a change of array or a gap that is too long between two bytes sends the decoder back to plain read mode. The reset byte does the same at any point. One command byte switches the decoder into a status-read mode. In that mode a read at a fixed low offset is flagged, so that the surrounding logic returns sector protection status there instead of array data.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the decoder is in read mode: `cmd_valid`, `status_mode` and `rd_status` are all 0.
- R2: Three accepted writes, in this order, make `cmd_valid` high for exactly one cycle, in the cycle after the third write, with `cmd_code` equal to the third data byte: data AAh at low-12-bit address 555h, then data 55h at low address AAAh, then any byte other than F0h at low address 555h. Address bits 15 to 12 do not matter.
- R3: A write whose data or low address differs from what the current step expects returns the decoder to read mode. No strobe follows, and the sequence must restart from its first write.
- R4: A write cycle is counted only while at least one bit of `prim_sel` or `boot_sel` is high. A write with no select line high changes nothing.
- R5: The target is primary (`cmd_target` = 0) when any `prim_sel` bit is high, and secondary (1) when only `boot_sel` bits are high. The target is fixed on the first unlock write. A later write in the same sequence with the other target aborts the sequence without a strobe.
- R6: Each sequence write must arrive no more than TIMEOUT_CYC cycles after the previous accepted write. If TIMEOUT_CYC cycles pass with no accepted write, the decoder returns to read mode.
- R7: The command byte 90h also sets `status_mode` to 1, and `status_target` holds the sequence's target. While the mode is set, `rd_status` is 1 during a read cycle whose low 8 address bits equal 02h and whose select lines include the status target. Otherwise it is 0.
- R8: An accepted write of F0h returns the decoder to read mode at any step, clears `status_mode`, and issues no strobe.
- R9: Read cycles (`bus_we` = 0) never change the sequence state, the timeout aside: reads between sequence writes do not break a sequence, and reads in status mode keep the mode.
- R10: Any accepted write in status mode clears `status_mode`. If that write is AAh at low address 555h, it also begins a new unlock sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_we | input | 1 | 1 for a write cycle, 0 for a read |
| bus_addr | input | ADDR_W | Bus address; only the low CMP_W bits are compared |
| bus_data | input | DATA_W | Write data byte |
| prim_sel | input | NUM_PRIM | Primary-array sector selects |
| boot_sel | input | NUM_BOOT | Secondary-array sector selects |
| cmd_valid | output | 1 | One-cycle decoded command strobe |
| cmd_code | output | DATA_W | Command byte, valid with the strobe |
| cmd_target | output | 1 | Array of the command: 0 primary, 1 secondary |
| status_mode | output | 1 | Status-read mode is active |
| status_target | output | 1 | Array that status-read mode applies to |
| rd_status | output | 1 | Current read must return protection status |

## Verification
The clocked properties assume that bus inputs are stable around the sampling edge and that a write takes exactly one clock cycle, so one accepted write equals one sequence step. The bench drives every cycle at the falling edge and ends each write after one cycle. It uses a short timeout, so that gap sweeps on both sides of the limit stay brief, and it sweeps full byte and offset ranges while keeping each sequence inside the timeout window unless the gap itself is under test.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
   typedef enum logic [1:0] {
      S_IDLE   = 2'd0,
      S_UNLK1  = 2'd1,
      S_UNLK2  = 2'd2,
      S_STATUS = 2'd3
   } fcd_state_e;

   localparam logic TGT_PRIMARY   = 1'b0;
   localparam logic TGT_SECONDARY = 1'b1;
endpackage

// File: rtl/fcd_bus_qual.sv
module fcd_bus_qual #(
   parameter int unsigned NUM_PRIM = 8,
   parameter int unsigned NUM_BOOT = 4
) (
   input  logic                bus_valid_i,
   input  logic                bus_we_i,
   input  logic [NUM_PRIM-1:0] prim_sel_i,
   input  logic [NUM_BOOT-1:0] boot_sel_i,
   output logic                wr_acc_o,
   output logic                rd_acc_o,
   output logic                wr_tgt_o,
   output logic                prim_any_o,
   output logic                boot_any_o
);
   import fcd_pkg::*;

   logic sel_any;

   assign prim_any_o = |prim_sel_i;
   assign boot_any_o = |boot_sel_i;
   assign sel_any    = prim_any_o | boot_any_o;

   // writes and reads only count toward the array while some select is high
   assign wr_acc_o = bus_valid_i &  bus_we_i & sel_any;
   assign rd_acc_o = bus_valid_i & ~bus_we_i & sel_any;

   // primary selects take precedence when both groups are asserted
   assign wr_tgt_o = prim_any_o ? TGT_PRIMARY : TGT_SECONDARY;
endmodule

// File: rtl/fcd_timeout.sv
module fcd_timeout #(
   parameter int unsigned LIMIT = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic kick_i,
   output logic expire_o
);
   localparam int unsigned CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

   generate
      if (LIMIT == 0) begin : g_off
         logic unused_ins;
         assign unused_ins = clk ^ rst_n ^ run_i ^ kick_i;
         assign expire_o   = 1'b0;
      end else begin : g_on
         logic [CNT_W-1:0] cnt_q;
         logic             at_lim;

         assign at_lim   = (cnt_q == CNT_W'(LIMIT - 1));
         assign expire_o = run_i & ~kick_i & at_lim;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!run_i || kick_i || expire_o) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         // R6: the gap counter never passes the last allowed idle cycle
         p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= CNT_W'(LIMIT - 1));

         // R6: an idle window closes the counter back to zero
         p_cnt_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
            expire_o |=> (cnt_q == '0));
      end
   endgenerate
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm #(
   parameter int unsigned        CMP_W      = 12,
   parameter int unsigned        DATA_W     = 8,
   parameter logic [CMP_W-1:0]   UNLOCK_A1  = 'h555,
   parameter logic [CMP_W-1:0]   UNLOCK_A2  = 'hAAA,
   parameter logic [DATA_W-1:0]  KEY1       = 'hAA,
   parameter logic [DATA_W-1:0]  KEY2       = 'h55,
   parameter logic [DATA_W-1:0]  CMD_RESET  = 'hF0,
   parameter logic [DATA_W-1:0]  CMD_STATUS = 'h90
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_acc_i,
   input  logic                  wr_tgt_i,
   input  logic [CMP_W-1:0]      addr_lo_i,
   input  logic [DATA_W-1:0]     data_i,
   input  logic                  expire_i,
   output fcd_pkg::fcd_state_e   state_o,
   output logic                  tgt_o,
   output logic                  cmd_valid_o,
   output logic [DATA_W-1:0]     cmd_code_o,
   output logic                  cmd_tgt_o
);
   import fcd_pkg::*;

   fcd_state_e        state_q, state_d;
   logic              tgt_q, tgt_d;
   logic              strobe_d;
   logic              is_reset, hit_a1, hit_a2, same_tgt;
   logic [DATA_W-1:0] code_q;
   logic              cmd_tgt_q, cmd_valid_q;

   assign is_reset = (data_i == CMD_RESET);
   assign hit_a1   = (addr_lo_i == UNLOCK_A1);
   assign hit_a2   = (addr_lo_i == UNLOCK_A2);
   assign same_tgt = (wr_tgt_i == tgt_q);

   always_comb begin
      state_d  = state_q;
      tgt_d    = tgt_q;
      strobe_d = 1'b0;
      if (wr_acc_i) begin
         if (is_reset) begin
            state_d = S_IDLE;
         end else begin
            unique case (state_q)
               S_IDLE, S_STATUS: begin
                  if (data_i == KEY1 && hit_a1) begin
                     state_d = S_UNLK1;
                     tgt_d   = wr_tgt_i;
                  end else begin
                     state_d = S_IDLE;
                  end
               end
               S_UNLK1: begin
                  state_d = (same_tgt && data_i == KEY2 && hit_a2) ? S_UNLK2 : S_IDLE;
               end
               S_UNLK2: begin
                  if (same_tgt && hit_a1) begin
                     strobe_d = 1'b1;
                     state_d  = (data_i == CMD_STATUS) ? S_STATUS : S_IDLE;
                  end else begin
                     state_d = S_IDLE;
                  end
               end
               default: state_d = S_IDLE;
            endcase
         end
      end else if (expire_i) begin
         state_d = S_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= S_IDLE;
         tgt_q       <= TGT_PRIMARY;
         cmd_valid_q <= 1'b0;
         code_q      <= '0;
         cmd_tgt_q   <= TGT_PRIMARY;
      end else begin
         state_q     <= state_d;
         tgt_q       <= tgt_d;
         cmd_valid_q <= strobe_d;
         if (strobe_d) begin
            code_q    <= data_i;
            cmd_tgt_q <= tgt_q;
         end
      end
   end

   assign state_o     = state_q;
   assign tgt_o       = tgt_q;
   assign cmd_valid_o = cmd_valid_q;
   assign cmd_code_o  = code_q;
   assign cmd_tgt_o   = cmd_tgt_q;

   // R2: a strobe only ever follows an accepted write in the command step
   p_strobe_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_q |-> $past(state_q == S_UNLK2 && wr_acc_i));

   // R2: the strobe lasts a single cycle
   p_strobe_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_q |=> !cmd_valid_q);

   // R4: without an accepted write, read mode is held
   p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_acc_i && state_q == S_IDLE) |=> (state_q == S_IDLE));

   // R5: the strobe carries the target latched on the first unlock write
   p_cmd_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_q |-> (cmd_tgt_q == $past(tgt_q)));

   // R6: an expired window ends the sequence
   p_expire_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_i && !wr_acc_i) |=> (state_q == S_IDLE));

   // R8: the reset byte lands in read mode with no strobe
   p_reset_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_acc_i && is_reset) |=> (state_q == S_IDLE && !cmd_valid_q));

   // R9: status mode survives cycles without an accepted write
   p_status_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_acc_i && state_q == S_STATUS) |=> (state_q == S_STATUS));

   // R10: an accepted write always leaves status mode
   p_status_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_acc_i && state_q == S_STATUS) |=> (state_q != S_STATUS));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
   parameter int unsigned       ADDR_W      = 16,
   parameter int unsigned       CMP_W       = 12,
   parameter int unsigned       STAT_W      = 8,
   parameter int unsigned       DATA_W      = 8,
   parameter int unsigned       NUM_PRIM    = 8,
   parameter int unsigned       NUM_BOOT    = 4,
   parameter int unsigned       TIMEOUT_CYC = 1024,
   parameter logic [CMP_W-1:0]  UNLOCK_A1   = 'h555,
   parameter logic [CMP_W-1:0]  UNLOCK_A2   = 'hAAA,
   parameter logic [DATA_W-1:0] KEY1        = 'hAA,
   parameter logic [DATA_W-1:0] KEY2        = 'h55,
   parameter logic [DATA_W-1:0] CMD_RESET   = 'hF0,
   parameter logic [DATA_W-1:0] CMD_STATUS  = 'h90,
   parameter logic [STAT_W-1:0] STATUS_OFS  = 'h02
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_valid,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_data,
   input  logic [NUM_PRIM-1:0] prim_sel,
   input  logic [NUM_BOOT-1:0] boot_sel,
   output logic                cmd_valid,
   output logic [DATA_W-1:0]   cmd_code,
   output logic                cmd_target,
   output logic                status_mode,
   output logic                status_target,
   output logic                rd_status
);
   import fcd_pkg::*;

   generate
      if (CMP_W > ADDR_W || CMP_W == 0) begin : g_bad_cmp
         $error("CMP_W must lie between 1 and ADDR_W");
      end
      if (STAT_W > CMP_W || STAT_W == 0) begin : g_bad_stat
         $error("STAT_W must lie between 1 and CMP_W");
      end
      if (NUM_PRIM == 0 || NUM_BOOT == 0) begin : g_bad_sel
         $error("each select group needs at least one line");
      end
      if (ADDR_W > CMP_W) begin : g_hi_ignored
         logic unused_hi;
         assign unused_hi = ^bus_addr[ADDR_W-1:CMP_W];
      end
   endgenerate

   logic              wr_acc, rd_acc, wr_tgt, prim_any, boot_any;
   logic              expire, seq_run, tgt;
   logic [CMP_W-1:0]  addr_lo;
   fcd_state_e        state;

   assign addr_lo = bus_addr[CMP_W-1:0];

   fcd_bus_qual #(
      .NUM_PRIM (NUM_PRIM),
      .NUM_BOOT (NUM_BOOT)
   ) u_qual (
      .bus_valid_i (bus_valid),
      .bus_we_i    (bus_we),
      .prim_sel_i  (prim_sel),
      .boot_sel_i  (boot_sel),
      .wr_acc_o    (wr_acc),
      .rd_acc_o    (rd_acc),
      .wr_tgt_o    (wr_tgt),
      .prim_any_o  (prim_any),
      .boot_any_o  (boot_any)
   );

   assign seq_run = (state == S_UNLK1) || (state == S_UNLK2);

   fcd_timeout #(
      .LIMIT (TIMEOUT_CYC)
   ) u_tmo (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (seq_run),
      .kick_i   (wr_acc),
      .expire_o (expire)
   );

   fcd_seq_fsm #(
      .CMP_W      (CMP_W),
      .DATA_W     (DATA_W),
      .UNLOCK_A1  (UNLOCK_A1),
      .UNLOCK_A2  (UNLOCK_A2),
      .KEY1       (KEY1),
      .KEY2       (KEY2),
      .CMD_RESET  (CMD_RESET),
      .CMD_STATUS (CMD_STATUS)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_acc_i    (wr_acc),
      .wr_tgt_i    (wr_tgt),
      .addr_lo_i   (addr_lo),
      .data_i      (bus_data),
      .expire_i    (expire),
      .state_o     (state),
      .tgt_o       (tgt),
      .cmd_valid_o (cmd_valid),
      .cmd_code_o  (cmd_code),
      .cmd_tgt_o   (cmd_target)
   );

   logic tgt_selected;
   assign tgt_selected  = (tgt == TGT_SECONDARY) ? boot_any : prim_any;
   assign status_mode   = (state == S_STATUS);
   assign status_target = tgt;
   assign rd_status     = rd_acc & status_mode & tgt_selected &
                          (addr_lo[STAT_W-1:0] == STATUS_OFS);

   // R7: status reads are flagged only while the mode is set and on reads
   p_rdstat_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_status |-> (!bus_we && bus_valid && status_mode));

   // R1: the decoder leaves reset with no strobe pending
   p_no_early_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !cmd_valid);
endmodule

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;
   localparam int TMO = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0, bus_we = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [7:0]  bus_data = '0;
   logic [7:0]  prim_sel = '0;
   logic [3:0]  boot_sel = '0;
   logic        cmd_valid, cmd_target, status_mode, status_target, rd_status;
   logic [7:0]  cmd_code;

   int nchk = 0, nfail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   flash_cmd_decoder #(.TIMEOUT_CYC(TMO)) uut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_data(bus_data), .prim_sel(prim_sel),
      .boot_sel(boot_sel), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .cmd_target(cmd_target), .status_mode(status_mode),
      .status_target(status_target), .rd_status(rd_status));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d,
                     input logic [7:0] p, input logic [3:0] b);
      @(negedge clk);
      bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_data = d;
      prim_sel = p; boot_sel = b;
      @(negedge clk);
      bus_valid = 1'b0; bus_we = 1'b0; prim_sel = '0; boot_sel = '0;
   endtask

   task automatic rd(input logic [15:0] a, input logic [7:0] p,
                     input logic [3:0] b, output logic flag);
      @(negedge clk);
      bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a; prim_sel = p; boot_sel = b;
      #1 flag = rd_status;
      @(negedge clk);
      bus_valid = 1'b0; prim_sel = '0; boot_sel = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic unlock(input logic [3:0] hi, input logic [7:0] p, input logic [3:0] b);
      wr({hi, 12'h555}, 8'hAA, p, b);
      wr({hi, 12'hAAA}, 8'h55, p, b);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         nchk++; nfail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

   initial begin : stim
      logic f;
      idle(3);
      rst_n = 1'b1;
      idle(2);
      // R1: reset state
      chk("R1 cmd_valid", cmd_valid, 0);
      chk("R1 status_mode", status_mode, 0);
      chk("R1 rd_status", rd_status, 0);

      // R2/R5/R7/R8: every command byte, upper nibble and target varied
      for (int c = 0; c < 256; c++) begin
         logic [7:0] p;
         logic [3:0] b;
         logic       t;
         t = c[0];
         p = t ? 8'h00 : (8'h01 << c[3:1]);
         b = t ? (4'h1 << c[2:1]) : 4'h0;
         unlock(c[7:4], p, b);
         wr({c[3:0], 12'h555}, c[7:0], p, b);
         chk("R2 R8 strobe", cmd_valid, (c != 8'hF0));
         if (c != 8'hF0) begin
            chk("R2 code", cmd_code, c);
            chk("R5 target", cmd_target, t);
         end
         chk("R7 mode", status_mode, (c == 8'h90));
         idle(1);
         chk("R2 pulse", cmd_valid, 0);
         if (c == 8'h90) begin
            chk("R7 status_target", status_target, t);
            wr(16'h1234, 8'hF0, p, b);
            chk("R8 exit", status_mode, 0);
         end
      end

      // R3: wrong first address
      for (int a = 0; a < 4096; a += 37) begin
         if (a != 12'h555) begin
            wr({4'h0, 12'(a)}, 8'hAA, 8'h01, 4'h0);
            wr(16'h0AAA, 8'h55, 8'h01, 4'h0);
            wr(16'h0555, 8'h11, 8'h01, 4'h0);
            chk("R3 addr1", cmd_valid, 0);
         end
      end
      // R3: wrong first and second data
      for (int d = 0; d < 256; d++) begin
         if (d != 8'hAA) begin
            wr(16'h0555, 8'(d), 8'h01, 4'h0);
            wr(16'h0AAA, 8'h55, 8'h01, 4'h0);
            wr(16'h0555, 8'h11, 8'h01, 4'h0);
            chk("R3 data1", cmd_valid, 0);
         end
         if (d != 8'h55) begin
            wr(16'h0555, 8'hAA, 8'h01, 4'h0);
            wr(16'h0AAA, 8'(d), 8'h01, 4'h0);
            wr(16'h0555, 8'h11, 8'h01, 4'h0);
            chk("R3 data2", cmd_valid, 0);
         end
      end
      // R3: wrong command address, then restart needed
      unlock(4'h0, 8'h01, 4'h0);
      wr(16'h0556, 8'h22, 8'h01, 4'h0);
      chk("R3 addr3", cmd_valid, 0);
      wr(16'h0555, 8'h22, 8'h01, 4'h0);
      chk("R3 restart", cmd_valid, 0);

      // R4: unselected writes do not count
      wr(16'h0555, 8'hAA, 8'h00, 4'h0);
      wr(16'h0AAA, 8'h55, 8'h01, 4'h0);
      wr(16'h0555, 8'h33, 8'h01, 4'h0);
      chk("R4 no select first", cmd_valid, 0);
      wr(16'h0555, 8'hAA, 8'h02, 4'h0);
      wr(16'h0123, 8'h77, 8'h00, 4'h0);
      wr(16'h0AAA, 8'h55, 8'h02, 4'h0);
      wr(16'h0555, 8'h33, 8'h02, 4'h0);
      chk("R4 junk ignored", cmd_valid, 1);
      chk("R4 code", cmd_code, 8'h33);

      // R5: target change aborts; both groups select primary
      wr(16'h0555, 8'hAA, 8'h01, 4'h0);
      wr(16'h0AAA, 8'h55, 8'h00, 4'h1);
      wr(16'h0555, 8'h44, 8'h00, 4'h1);
      chk("R5 target change", cmd_valid, 0);
      unlock(4'h3, 8'h80, 4'h8);
      wr(16'h3555, 8'h45, 8'h80, 4'h8);
      chk("R5 both strobe", cmd_valid, 1);
      chk("R5 both primary", cmd_target, 0);

      // R6: gap sweep after second and after first byte
      for (int n = 0; n < TMO + 3; n++) begin
         unlock(4'h0, 8'h01, 4'h0);
         idle(n);
         wr(16'h0555, 8'h66, 8'h01, 4'h0);
         chk("R6 gap2", cmd_valid, (n + 2 <= TMO));
         wr(16'h0555, 8'hAA, 8'h01, 4'h0);
         idle(n);
         wr(16'h0AAA, 8'h55, 8'h01, 4'h0);
         wr(16'h0555, 8'h67, 8'h01, 4'h0);
         chk("R6 gap1", cmd_valid, (n + 2 <= TMO));
      end

      // R7: status read offsets
      unlock(4'h0, 8'h04, 4'h0);
      wr(16'h0555, 8'h90, 8'h04, 4'h0);
      for (int a = 0; a < 256; a++) begin
         rd({4'(a), 4'(a >> 4), 8'(a)}, 8'h04, 4'h0, f);
         chk("R7 offset", f, (a == 2));
      end
      rd(16'h0002, 8'h00, 4'h2, f);
      chk("R7 other array", f, 0);
      // R9: reads keep status mode
      chk("R9 mode kept", status_mode, 1);
      // R10: plain write leaves status mode
      wr(16'h0000, 8'h12, 8'h04, 4'h0);
      chk("R10 exit", status_mode, 0);
      rd(16'h0002, 8'h04, 4'h0, f);
      chk("R10 rd after exit", f, 0);
      // R10: unlock from status mode starts a sequence
      unlock(4'h0, 8'h01, 4'h0);
      wr(16'h0555, 8'h90, 8'h01, 4'h0);
      wr(16'h0555, 8'hAA, 8'h01, 4'h0);
      chk("R10 mode cleared", status_mode, 0);
      wr(16'h0AAA, 8'h55, 8'h01, 4'h0);
      wr(16'h0555, 8'h5A, 8'h01, 4'h0);
      chk("R10 new seq", cmd_valid, 1);

      // R9: reads inside a sequence
      wr(16'h0555, 8'hAA, 8'h01, 4'h0);
      rd(16'h0555, 8'h01, 4'h0, f);
      wr(16'h0AAA, 8'h55, 8'h01, 4'h0);
      rd(16'h0AAA, 8'h01, 4'h0, f);
      wr(16'h0555, 8'h3C, 8'h01, 4'h0);
      chk("R9 reads mid seq", cmd_valid, 1);

      // R8: reset byte mid sequence
      unlock(4'h0, 8'h01, 4'h0);
      wr(16'h0777, 8'hF0, 8'h01, 4'h0);
      wr(16'h0555, 8'h3D, 8'h01, 4'h0);
      chk("R8 mid abort", cmd_valid, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule